// File: doc/BRIEF.md
# Systolic Three-Tap Convolution Pipeline

This block computes a streaming finite-impulse-response convolution on a linear chain of processing cells. Each accepted input sample is captured by the first cell and then handed from cell to cell, one position per accepted sample. Each cell multiplies the sample it currently sees by one of its locally held coefficients. The resulting products are then summed along the chain in a skewed adder pipeline. Every sample is therefore reused by every cell without being fetched again. The multiply and the add in each cell sit in different register stages, so the product of one sample and the partial sum of an earlier one are formed in the same clock cycle.

Each cell keeps two coefficient banks. A bank-select input travels with each sample, so software can load a new coefficient set into the idle bank while streaming continues. It can then switch to that bank on any sample boundary, for example for adaptive filtering. Results leave with a valid flag after a fixed pipeline latency. Gaps in the input stream reappear as gaps in the output stream.

Top module: `sfir_array`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0, out_data is 0, all coefficients in both banks are 0 and the sample history is 0.
- R2: For accepted sample x(n) with selected bank b, the result is the sum over tap t of coef[b][t] * x(n-(TAPS-1)+t). Tap 0 weights the oldest sample and tap TAPS-1 weights x(n).
- R3: Sample history that precedes the first accepted sample after reset counts as 0. The first TAPS-1 results therefore contain only the taps that have real samples.
- R4: A sample accepted at clock edge k (in_valid high at that edge) yields out_valid high, with its result on out_data, during the cycle that follows edge k+TAPS. This is 3 edges later with the default parameters.
- R5: Exactly one result is produced for each accepted sample, in acceptance order. No result appears for cycles with in_valid low, and an input gap gives an output gap of the same length.
- R6: The sample history advances only on accepted samples. Idle cycles between samples do not change which samples a result combines.
- R7: in_bank is sampled together with each accepted sample (0 selects bank 0, 1 selects bank 1). All taps of that sample's result use that bank, so a switch takes effect exactly at the next accepted sample.
- R8: With wl_en high at an edge, wl_data is written to tap wl_tap (0 = oldest-sample tap) of bank wl_bank. No other coefficient changes, no output is produced, and samples accepted at later edges use the new value.
- R9: Samples and coefficients are 8-bit two's complement values, and out_data is a 20-bit two's complement sum that wraps on overflow.
- R10: When a load and an accepted sample share an edge, that sample uses the coefficient value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | 8 | Signed input sample |
| in_bank | input | 1 | Coefficient bank for this sample |
| wl_en | input | 1 | Coefficient write strobe |
| wl_tap | input | 2 | Tap index to write (0 = oldest-sample tap) |
| wl_bank | input | 1 | Bank to write |
| wl_data | input | 8 | Signed coefficient value |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 20 | Signed convolution result |

## Verification
The assertions check structural properties on every cycle. Each product leaves its skew line in the same cycle as the partial sum it joins. The count of results in flight never exceeds the pipeline depth, and no result emerges before TAPS+1 edges have passed since reset. Idle cycles leave the sample history untouched, and a coefficient holds its value unless it is written. Only the scoreboard scenarios can show that the numbers are right. These cover the zero-history start, back-to-back and gapped streams, a bank switch partway through, a load into the idle bank and a load that collides with an accepted sample, with the exact arrival cycle of every result checked as well.

// File: rtl/sfir_pkg.sv
`timescale 1ns/1ps
package sfir_pkg;

  // Index width that never collapses to zero bits.
  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sfir_coef_store.sv
`timescale 1ns/1ps
module sfir_coef_store #(
  parameter int COEF_W = 8,
  parameter int NBANK  = 2,
  parameter int BANK_W = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [BANK_W-1:0]        wr_bank,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic [BANK_W-1:0]        rd_bank,
  output logic signed [COEF_W-1:0] rd_data
);

  logic signed [COEF_W-1:0] mem [NBANK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANK; b++) mem[b] <= '0;
    end else if (wr_en) begin
      mem[wr_bank] <= wr_data;
    end
  end

  // Asynchronous read: a write at the same edge is seen by later samples only.
  assign rd_data = mem[rd_bank];

  for (genvar b = 0; b < NBANK; b++) begin : g_hold
    // R8
    coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_bank == BANK_W'(b)) |=> $stable(mem[b]));
  end

endmodule

// File: rtl/sfir_cell.sv
`timescale 1ns/1ps
module sfir_cell #(
  parameter int IDX    = 0,
  parameter int SAMP_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 20,
  parameter int NBANK  = 2,
  parameter int BANK_W = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic signed [SAMP_W-1:0] smp_in,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic                     wr_en,
  input  logic [BANK_W-1:0]        wr_bank,
  input  logic signed [COEF_W-1:0] wr_data,
  output logic signed [SAMP_W-1:0] smp_out,
  input  logic signed [ACC_W-1:0]  psum_in,
  input  logic                     psum_in_vld,
  output logic signed [ACC_W-1:0]  psum_out,
  output logic                     psum_out_vld
);

  localparam int PROD_W = SAMP_W + COEF_W;

  logic signed [SAMP_W-1:0] smp_q;
  logic signed [COEF_W-1:0] coef;
  logic signed [PROD_W-1:0] prod_c, prod_q, dly_prod;
  logic                     prod_vld, dly_vld;
  logic signed [ACC_W-1:0]  prod_ext;

  // Sample register: hands the sample on to the next cell per accepted sample.
  always_ff @(posedge clk) begin
    if (rst)       smp_q <= '0;
    else if (take) smp_q <= smp_in;
  end
  assign smp_out = smp_q;

  sfir_coef_store #(
    .COEF_W (COEF_W),
    .NBANK  (NBANK),
    .BANK_W (BANK_W)
  ) u_coef (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_bank (wr_bank),
    .wr_data (wr_data),
    .rd_bank (bank_sel),
    .rd_data (coef)
  );

  // Multiply stage.
  assign prod_c = smp_in * coef;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q   <= '0;
      prod_vld <= 1'b0;
    end else begin
      prod_vld <= take;
      if (take) prod_q <= prod_c;
    end
  end

  // Skew line: cell IDX waits IDX cycles so its product meets the partial sum.
  if (IDX == 0) begin : g_noskew
    assign dly_prod = prod_q;
    assign dly_vld  = prod_vld;
  end else begin : g_skew
    logic signed [PROD_W-1:0] sp [IDX];
    logic [IDX-1:0]           sv;

    always_ff @(posedge clk) begin
      if (rst) begin
        sv <= '0;
        for (int k = 0; k < IDX; k++) sp[k] <= '0;
      end else begin
        sv[0] <= prod_vld;
        sp[0] <= prod_q;
        for (int k = 1; k < IDX; k++) begin
          sv[k] <= sv[k-1];
          sp[k] <= sp[k-1];
        end
      end
    end
    assign dly_prod = sp[IDX-1];
    assign dly_vld  = sv[IDX-1];

    // R4
    skew_align_chk: assert property (@(posedge clk) disable iff (rst)
      dly_vld == psum_in_vld);
  end

  // Add stage.
  assign prod_ext = $signed({{(ACC_W-PROD_W){dly_prod[PROD_W-1]}}, dly_prod});

  always_ff @(posedge clk) begin
    if (rst) begin
      psum_out     <= '0;
      psum_out_vld <= 1'b0;
    end else begin
      psum_out_vld <= dly_vld & psum_in_vld;
      if (dly_vld) psum_out <= psum_in + prod_ext;
    end
  end

endmodule

// File: rtl/sfir_array.sv
`timescale 1ns/1ps
module sfir_array #(
  parameter int TAPS   = 3,
  parameter int SAMP_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 20,
  parameter int NBANK  = 2
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       in_valid,
  input  logic signed [SAMP_W-1:0]                   in_data,
  input  logic [sfir_pkg::idx_w(NBANK)-1:0]          in_bank,
  input  logic                                       wl_en,
  input  logic [sfir_pkg::idx_w(TAPS)-1:0]           wl_tap,
  input  logic [sfir_pkg::idx_w(NBANK)-1:0]          wl_bank,
  input  logic signed [COEF_W-1:0]                   wl_data,
  output logic                                       out_valid,
  output logic signed [ACC_W-1:0]                    out_data
);

  localparam int BANK_W = sfir_pkg::idx_w(NBANK);
  localparam int TAP_W  = sfir_pkg::idx_w(TAPS);
  localparam int CNT_W  = $clog2(TAPS + 3);

  logic [TAPS-1:0][SAMP_W-1:0] hist;
  logic signed [ACC_W-1:0]     psum [TAPS];
  logic [TAPS-1:0]             psum_vld;

  for (genvar j = 0; j < TAPS; j++) begin : g_cell
    logic signed [SAMP_W-1:0] c_in;
    logic signed [ACC_W-1:0]  s_in;
    logic                     s_in_vld;
    logic                     c_wr;

    if (j == 0) begin : g_head
      assign c_in     = in_data;
      assign s_in     = '0;
      assign s_in_vld = 1'b1;
    end else begin : g_body
      assign c_in     = $signed(hist[j-1]);
      assign s_in     = psum[j-1];
      assign s_in_vld = psum_vld[j-1];
    end

    // Cell j sees x(n-j), which tap TAPS-1-j weights.
    assign c_wr = wl_en && (wl_tap == TAP_W'(TAPS - 1 - j));

    sfir_cell #(
      .IDX    (j),
      .SAMP_W (SAMP_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W),
      .NBANK  (NBANK),
      .BANK_W (BANK_W)
    ) u_cell (
      .clk          (clk),
      .rst          (rst),
      .take         (in_valid),
      .smp_in       (c_in),
      .bank_sel     (in_bank),
      .wr_en        (c_wr),
      .wr_bank      (wl_bank),
      .wr_data      (wl_data),
      .smp_out      (hist[j]),
      .psum_in      (s_in),
      .psum_in_vld  (s_in_vld),
      .psum_out     (psum[j]),
      .psum_out_vld (psum_vld[j])
    );
  end

  assign out_valid = psum_vld[TAPS-1];
  assign out_data  = psum[TAPS-1];

  // Checker state: results in flight and edges since reset.
  logic [CNT_W-1:0] inflight, since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight  <= '0;
      since_rst <= '0;
    end else begin
      inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
      if (since_rst != CNT_W'(TAPS + 1)) since_rst <= since_rst + 1'b1;
    end
  end

  // R5
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNT_W'(TAPS + 1));

  // R5
  out_has_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> inflight != '0);

  // R4
  early_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> since_rst == CNT_W'(TAPS + 1));

  // R6
  idle_hist_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(hist));

endmodule

// File: tb/sfir_array_bench.sv
`timescale 1ns/1ps
module sfir_array_bench;

  localparam int TAPS = 3;
  localparam int SW   = 8;
  localparam int CW   = 8;
  localparam int AW   = 20;
  localparam int NB   = 2;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_bank, wl_en, wl_bank;
  logic signed [SW-1:0] in_data;
  logic [1:0] wl_tap;
  logic signed [CW-1:0] wl_data;
  logic out_valid;
  logic signed [AW-1:0] out_data;

  always #2.5 clk = ~clk;

  sfir_array u_sfir_array (
    .clk (clk), .rst (rst),
    .in_valid (in_valid), .in_data (in_data), .in_bank (in_bank),
    .wl_en (wl_en), .wl_tap (wl_tap), .wl_bank (wl_bank), .wl_data (wl_data),
    .out_valid (out_valid), .out_data (out_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  int wm [NB][TAPS];
  int hist [TAPS-1];
  logic [AW-1:0] q_data [$];
  int q_cyc [$];
  string q_tag [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // One clock of stimulus; the expected result is pushed before the model load.
  task automatic drive(input bit v, input int x, input int s, input bit we,
                       input int wb, input int wt, input int wd, input string tag);
    @(negedge clk);
    in_valid = v;  in_data = x[SW-1:0];  in_bank = s[0];
    wl_en = we;    wl_bank = wb[0];      wl_tap = wt[1:0];  wl_data = wd[CW-1:0];
    if (v) begin
      int y;
      y = wm[s][TAPS-1] * x;
      for (int k = 1; k < TAPS; k++) y += wm[s][TAPS-1-k] * hist[k-1];
      q_data.push_back(y[AW-1:0]);
      q_cyc.push_back(cyc + 1 + TAPS);
      q_tag.push_back(tag);
      for (int k = TAPS-2; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
    end
    if (we) wm[wb][wt] = wd;
  endtask

  task automatic send(input int x, input int s, input string tag);
    drive(1'b1, x, s, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic load(input int b, input int t, input int d);
    drive(1'b0, 0, 0, 1'b1, b, t, d, "R8");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 1'b0, 0, 0, 0, "");
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R5", "unexpected out_valid", 1, 0);
      end else begin
        logic [AW-1:0] e;
        int ec;
        string tg;
        e = q_data.pop_front();
        ec = q_cyc.pop_front();
        tg = q_tag.pop_front();
        chk(out_data == $signed(e), tg, "out_data", out_data, $signed(e));
        chk(cyc == ec, "R4", "arrival cycle", cyc, ec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int t = 0; t < TAPS; t++) wm[b][t] = 0;
    for (int k = 0; k < TAPS-1; k++) hist[k] = 0;
    rst = 1'b1;
    in_valid = 0; in_data = 0; in_bank = 0;
    wl_en = 0; wl_bank = 0; wl_tap = 0; wl_data = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle(3);
    // R1: idle outputs after reset
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(out_data == '0, "R1", "out_data after reset", out_data, 0);

    // R1: zero coefficients after reset give zero results
    send(9, 0, "R1");
    send(-4, 1, "R1");
    idle(6);
    // Reset again so the history starts from zero for R3.
    @(negedge clk) rst = 1'b1;
    for (int k = 0; k < TAPS-1; k++) hist[k] = 0;
    @(negedge clk) rst = 1'b0;

    // R8: loads produce no output
    load(0, 0, 1); load(0, 1, 2); load(0, 2, 3);
    load(1, 0, -1); load(1, 1, 4); load(1, 2, -5);
    idle(5);

    // R3 then R2: back-to-back stream from zero history
    send(5, 0, "R3");
    send(7, 0, "R3");
    send(-3, 0, "R2");
    send(10, 0, "R2");
    send(2, 0, "R2");
    // R5 / R6: gaps
    idle(1);
    send(4, 0, "R6");
    idle(2);
    send(-6, 0, "R6");
    idle(1);
    send(9, 0, "R5");
    // R7: bank switch mid-stream
    send(1, 1, "R7");
    send(2, 1, "R7");
    send(3, 0, "R7");
    send(4, 1, "R7");
    // R8: load idle bank while streaming, then use it
    drive(1'b1, 6, 0, 1'b1, 1, 0, 7, "R8");
    send(-2, 1, "R8");
    // R10: collision on the active bank and tap
    drive(1'b1, 11, 0, 1'b1, 0, 2, -8, "R10");
    send(5, 0, "R10");
    idle(2);
    // R9: signed extremes
    load(0, 0, -128); load(0, 1, -128); load(0, 2, -128);
    send(-128, 0, "R9");
    send(-128, 0, "R9");
    send(-128, 0, "R9");
    send(127, 0, "R9");
    send(127, 0, "R9");
    idle(10);

    done = 1'b1;
    chk(q_data.size() == 0, "R5", "results missing", q_data.size(), 0);
    summary();
    $finish;
  end

endmodule